// File: doc/BRIEF.md
# Hybrid Period/Duty Regulation Controller

This block closes a digital output-voltage loop with two knobs. The coarse knob is the switching-period count. The fine knob is the duty count. The block receives one signed error sample per control cycle, flagged by a valid pulse. It adds that sample to an internal error sum and checks the new sum against a symmetric window.

While the sum stays inside the window, only the duty is trimmed. A proportional-integral term, built from arithmetic shifts, moves a fractional duty ratio around its initial value. That ratio is clamped to a narrow band so that dead time stays safe. When the sum leaves the window, the period moves by exactly one count. In the same update the duty returns to its initial ratio and the sum is cleared.

The period and duty counts are registered together and announced with a single update strobe, so that a downstream gate-pulse generator can load both at once on its own period boundary. Error samples are Q2.14. The window edges are ±0x1000, which is ±0.25. Duty fractions are unsigned Q0.12 (4096 = 100%).

Top module: `hybrid_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs take period 75, duty 65 (the count for the initial ratio 3564/4096 at period 75), `upd_strobe` 0 and `step_taken` 0, and the error sum is cleared to zero.
- R2: A cycle with `err_valid` low leaves `period_cnt` and `duty_cnt` unchanged, keeps `upd_strobe` low and does not change the error sum, whatever value `err_in` holds.
- R3: When `err_valid` is high and the new sum S (old sum plus `err_in`) lies within -4096..+4096 inclusive, the period is unchanged, the sum becomes S, and the duty fraction is 3564 + (S >>> 4) + (`err_in` >>> 3), using arithmetic shifts.
- R4: When S > +4096, the period count decreases by one.
- R5: When S < -4096, the period count increases by one.
- R6: The period count never goes below 60 or above 90. A step that would pass a bound leaves the period unchanged, but it still restores the duty ratio and clears the sum.
- R7: In duty mode the duty fraction is clamped to 3441..3686 (about 84% to 90%).
- R8: `duty_cnt` equals (`period_cnt` × fraction + 2048) >> 12, that is, the fraction applied to the new period and rounded to the nearest count. After a step, the fraction is the initial 3564.
- R9: One cycle after each valid sample, `upd_strobe` is high for exactly one cycle. Period and duty change only on that cycle. `step_taken` is high with the strobe exactly when that sample caused a period step decision.
- R10: After a step the sum is zero, so the next sample starts from a neutral point. The stored sum never lies outside ±4096.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | One-cycle pulse marking a new error sample |
| err_in | input | 16 | Signed Q2.14 voltage error (positive: output too low) |
| period_cnt | output | 8 | Switching period in base-clock counts |
| duty_cnt | output | 8 | On-time in base-clock counts |
| upd_strobe | output | 1 | Period and duty were updated this cycle |
| step_taken | output | 1 | The last update was a period step |

## Verification
The assertions watch, on every cycle, that a strobe follows each valid sample and that nothing moves without one. They also check that the period stays inside its limits, that a duty-mode update leaves the period alone, and that the stored sum never escapes the window and is zero after every step. Only the directed scenarios can show the exact numbers: the proportional-integral arithmetic, the rounding of the duty count, the direction of each step, duty clamping at both ends, and the period bounds reached after long runs of steps. The bench also shows that a ignored sample has no effect, by sending a zero-error sample afterwards and checking that the duty reflects an unchanged sum.

// File: rtl/hmc_pkg.sv
package hmc_pkg;
    typedef enum logic {
        MODE_DUTY = 1'b0,
        MODE_FREQ = 1'b1
    } mode_e;
endpackage

// File: rtl/hmc_err_accum.sv
module hmc_err_accum
    import hmc_pkg::*;
#(
    parameter int ERR_W  = 16,
    parameter int ACC_W  = 18,
    parameter int BORDER = 4096
) (
    input  logic signed [ACC_W-1:0] acc_q,
    input  logic signed [ERR_W-1:0] err,
    output logic signed [ACC_W-1:0] sum,
    output logic                    cross_hi,
    output logic                    cross_lo,
    output mode_e                   mode
);
    localparam logic signed [ACC_W-1:0] HI_S = ACC_W'(BORDER);
    localparam logic signed [ACC_W-1:0] LO_S = -HI_S;

    logic signed [ACC_W-1:0] err_x;

    always_comb begin
        err_x    = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
        sum      = acc_q + err_x;
        cross_hi = (sum > HI_S);
        cross_lo = (sum < LO_S);
        mode     = (cross_hi || cross_lo) ? MODE_FREQ : MODE_DUTY;
    end
endmodule

// File: rtl/hmc_period_step.sv
module hmc_period_step #(
    parameter int PER_W   = 8,
    parameter int PER_MIN = 60,
    parameter int PER_MAX = 90
) (
    input  logic [PER_W-1:0] period_q,
    input  logic             cross_hi,
    input  logic             cross_lo,
    output logic [PER_W-1:0] period_d
);
    localparam logic [PER_W-1:0] MIN_C = PER_W'(PER_MIN);
    localparam logic [PER_W-1:0] MAX_C = PER_W'(PER_MAX);
    localparam logic [PER_W-1:0] ONE_C = PER_W'(1);

    always_comb begin
        period_d = period_q;
        if (cross_hi) begin
            if (period_q > MIN_C) period_d = period_q - ONE_C;
        end else if (cross_lo) begin
            if (period_q < MAX_C) period_d = period_q + ONE_C;
        end
    end
endmodule

// File: rtl/hmc_duty_calc.sv
module hmc_duty_calc #(
    parameter int ERR_W     = 16,
    parameter int ACC_W     = 18,
    parameter int PER_W     = 8,
    parameter int FRAC_W    = 12,
    parameter int DUTY_INIT = 3564,
    parameter int DUTY_MIN  = 3441,
    parameter int DUTY_MAX  = 3686,
    parameter int KI_SH     = 4,
    parameter int KP_SH     = 3
) (
    input  logic signed [ACC_W-1:0] sum,
    input  logic signed [ERR_W-1:0] err,
    input  logic [PER_W-1:0]        period_d,
    input  logic                    restart,
    output logic [PER_W-1:0]        duty_d
);
    localparam int SW = ACC_W + 2;
    localparam int PW = PER_W + FRAC_W + 1;
    localparam logic signed [SW-1:0] INIT_S = SW'(DUTY_INIT);
    localparam logic signed [SW-1:0] MIN_S  = SW'(DUTY_MIN);
    localparam logic signed [SW-1:0] MAX_S  = SW'(DUTY_MAX);
    localparam logic [PW-1:0]        HALF   = PW'(1) << (FRAC_W - 1);

    logic signed [SW-1:0] sum_x, err_x, i_term, p_term, raw;
    logic [FRAC_W-1:0]    frac;
    logic [PW-1:0]        prod;

    always_comb begin
        sum_x  = {{(SW-ACC_W){sum[ACC_W-1]}}, sum};
        err_x  = {{(SW-ERR_W){err[ERR_W-1]}}, err};
        i_term = sum_x >>> KI_SH;
        p_term = err_x >>> KP_SH;
        raw    = INIT_S + i_term + p_term;
        if (restart)          frac = FRAC_W'(INIT_S);
        else if (raw < MIN_S) frac = FRAC_W'(MIN_S);
        else if (raw > MAX_S) frac = FRAC_W'(MAX_S);
        else                  frac = FRAC_W'(raw);
        prod   = PW'(period_d) * PW'(frac) + HALF;
        duty_d = prod[FRAC_W +: PER_W];
    end
endmodule

// File: rtl/hybrid_mode_ctrl.sv
module hybrid_mode_ctrl
    import hmc_pkg::*;
#(
    parameter int ERR_W     = 16,
    parameter int PER_W     = 8,
    parameter int FRAC_W    = 12,
    parameter int DEF_PER   = 75,
    parameter int PER_MIN   = 60,
    parameter int PER_MAX   = 90,
    parameter int BORDER    = 4096,
    parameter int DUTY_INIT = 3564,
    parameter int DUTY_MIN  = 3441,
    parameter int DUTY_MAX  = 3686,
    parameter int KI_SH     = 4,
    parameter int KP_SH     = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    err_valid,
    input  logic signed [ERR_W-1:0] err_in,
    output logic [PER_W-1:0]        period_cnt,
    output logic [PER_W-1:0]        duty_cnt,
    output logic                    upd_strobe,
    output logic                    step_taken
);
    localparam int ACC_W    = ERR_W + 2;
    localparam int DEF_DUTY = (DEF_PER * DUTY_INIT + (1 << (FRAC_W - 1))) >> FRAC_W;
    localparam logic signed [ACC_W-1:0] WIN_S = ACC_W'(BORDER);

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [PER_W-1:0]        per;
        logic [PER_W-1:0]        duty;
        logic                    strobe;
        logic                    step;
    } state_t;

    localparam state_t RST_STATE = '{
        acc:    '0,
        per:    PER_W'(DEF_PER),
        duty:   PER_W'(DEF_DUTY),
        strobe: 1'b0,
        step:   1'b0
    };

    state_t state_q, state_d;

    logic signed [ACC_W-1:0] sum;
    logic                    cross_hi, cross_lo;
    mode_e                   mode;
    logic [PER_W-1:0]        period_d;
    logic [PER_W-1:0]        duty_d;

    hmc_err_accum #(
        .ERR_W (ERR_W),
        .ACC_W (ACC_W),
        .BORDER(BORDER)
    ) u_accum (
        .acc_q   (state_q.acc),
        .err     (err_in),
        .sum     (sum),
        .cross_hi(cross_hi),
        .cross_lo(cross_lo),
        .mode    (mode)
    );

    hmc_period_step #(
        .PER_W  (PER_W),
        .PER_MIN(PER_MIN),
        .PER_MAX(PER_MAX)
    ) u_step (
        .period_q(state_q.per),
        .cross_hi(cross_hi),
        .cross_lo(cross_lo),
        .period_d(period_d)
    );

    hmc_duty_calc #(
        .ERR_W    (ERR_W),
        .ACC_W    (ACC_W),
        .PER_W    (PER_W),
        .FRAC_W   (FRAC_W),
        .DUTY_INIT(DUTY_INIT),
        .DUTY_MIN (DUTY_MIN),
        .DUTY_MAX (DUTY_MAX),
        .KI_SH    (KI_SH),
        .KP_SH    (KP_SH)
    ) u_duty (
        .sum     (sum),
        .err     (err_in),
        .period_d(period_d),
        .restart (mode == MODE_FREQ),
        .duty_d  (duty_d)
    );

    always_comb begin
        state_d        = state_q;
        state_d.strobe = 1'b0;
        state_d.step   = 1'b0;
        if (err_valid) begin
            state_d.strobe = 1'b1;
            state_d.per    = period_d;
            state_d.duty   = duty_d;
            if (mode == MODE_FREQ) begin
                state_d.step = 1'b1;
                state_d.acc  = '0;
            end else begin
                state_d.acc  = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RST_STATE;
        else     state_q <= state_d;
    end

    assign period_cnt = state_q.per;
    assign duty_cnt   = state_q.duty;
    assign upd_strobe = state_q.strobe;
    assign step_taken = state_q.step;

    AST_STROBE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> upd_strobe); // R9
    AST_HOLD_WITHOUT_VALID: assert property (@(posedge clk) disable iff (rst)
        !err_valid |=> (!upd_strobe && $stable(period_cnt) && $stable(duty_cnt))); // R2
    AST_PERIOD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (period_cnt >= PER_W'(PER_MIN)) && (period_cnt <= PER_W'(PER_MAX))); // R6
    AST_DUTY_MODE_KEEPS_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (upd_strobe && !step_taken) |-> $stable(period_cnt)); // R3
    AST_STEP_CLEARS_SUM: assert property (@(posedge clk) disable iff (rst)
        step_taken |-> (state_q.acc == '0)); // R10
    AST_SUM_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (state_q.acc <= WIN_S) && (state_q.acc >= -WIN_S)); // R10
    AST_DUTY_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
        duty_cnt < period_cnt); // R7
endmodule

// File: tb/hybrid_mode_ctrl_tb.sv
module hybrid_mode_ctrl_tb;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               err_valid = 1'b0;
    logic signed [15:0] err_in = '0;
    logic [7:0]         period_cnt, duty_cnt;
    logic               upd_strobe, step_taken;

    int n_tests = 0;
    int n_fail  = 0;
    int m_acc   = 0;
    int m_per   = 75;
    int m_duty  = 65;
    int m_step  = 0;

    always #4 clk = ~clk;

    hybrid_mode_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .err_valid (err_valid),
        .err_in    (err_in),
        .period_cnt(period_cnt),
        .duty_cnt  (duty_cnt),
        .upd_strobe(upd_strobe),
        .step_taken(step_taken)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int duty_of(input int per, input int frac);
        return (per * frac + 2048) >> 12;
    endfunction

    task automatic model(input int e);
        int s, f;
        s = m_acc + e;
        if (s > 4096) begin
            m_step = 1;
            if (m_per > 60) m_per--;
            m_duty = duty_of(m_per, 3564);
            m_acc  = 0;
        end else if (s < -4096) begin
            m_step = 1;
            if (m_per < 90) m_per++;
            m_duty = duty_of(m_per, 3564);
            m_acc  = 0;
        end else begin
            m_step = 0;
            f = 3564 + (s >>> 4) + (e >>> 3);
            if (f < 3441) f = 3441;
            if (f > 3686) f = 3686;
            m_duty = duty_of(m_per, f);
            m_acc  = s;
        end
    endtask

    task automatic send(input int e, input string req);
        @(negedge clk);
        err_valid = 1'b1;
        err_in    = 16'(e);
        @(negedge clk);
        err_valid = 1'b0;
        err_in    = 16'h5A5A;
        model(e);
        chk(req, "strobe", int'(upd_strobe), 1);
        chk(req, "step", int'(step_taken), m_step);
        chk(req, "period", int'(period_cnt), m_per);
        chk(req, "duty", int'(duty_cnt), m_duty);
    endtask

    task automatic t_reset();
        chk("R1", "period", int'(period_cnt), 75);
        chk("R1", "duty", int'(duty_cnt), 65);
        chk("R1", "strobe", int'(upd_strobe), 0);
        chk("R1", "step", int'(step_taken), 0);
        send(0, "R1"); // zero sum after reset gives initial duty
    endtask

    task automatic t_duty_trim();
        send(256, "R3");
        chk("R3", "duty small error", int'(duty_cnt), 66);
        send(-512, "R3");
        send(0, "R3");
    endtask

    task automatic t_ignore();
        int p, d;
        send(1000, "R2");
        p = int'(period_cnt);
        d = int'(duty_cnt);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            err_in = 16'(3000 * (i + 1));
            chk("R2", "strobe low", int'(upd_strobe), 0);
            chk("R2", "period held", int'(period_cnt), p);
            chk("R2", "duty held", int'(duty_cnt), d);
        end
        send(0, "R2"); // duty shows sum unchanged by ignored samples
        @(negedge clk);
        chk("R9", "strobe single cycle", int'(upd_strobe), 0);
    endtask

    task automatic t_cross_pos();
        send(-m_acc, "R10");
        send(2048, "R3");
        send(2048, "R3"); // exactly on the edge: duty mode
        chk("R3", "edge no step", int'(step_taken), 0);
        send(2304, "R4");
        chk("R4", "period down", int'(period_cnt), 74);
        chk("R8", "duty restart", int'(duty_cnt), 64);
        send(100, "R10"); // fresh sum of 100
    endtask

    task automatic t_cross_neg();
        send(-m_acc, "R10");
        send(-4097, "R5");
        chk("R5", "period up", int'(period_cnt), 75);
        chk("R9", "step flag", int'(step_taken), 1);
    endtask

    task automatic t_clamp();
        send(-m_acc, "R7");
        send(-4096, "R7");
        chk("R7", "duty at min", int'(duty_cnt), duty_of(m_per, 3441));
        send(8192, "R7");
        chk("R7", "duty at max", int'(duty_cnt), duty_of(m_per, 3686));
    endtask

    task automatic t_period_bounds();
        send(-m_acc, "R6");
        for (int i = 0; i < 18; i++) send(4097, "R6");
        chk("R6", "period at min", int'(period_cnt), 60);
        chk("R6", "step at min", int'(step_taken), 1);
        for (int i = 0; i < 34; i++) send(-4097, "R6");
        chk("R6", "period at max", int'(period_cnt), 90);
        send(300, "R10");
        chk("R10", "sum restarted", int'(duty_cnt), duty_of(90, 3564 + (300 >>> 4) + (300 >>> 3)));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_duty_trim();
        t_ignore();
        t_cross_pos();
        t_cross_neg();
        t_clamp();
        t_period_bounds();
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule